// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block counts hardware events for profiling. It holds a configurable number of general event counters and one dedicated cycle counter. Every clock cycle it samples a vector of single-cycle event pulses. Each general counter picks the pulse it follows through an event number in its own type register. Counting is gated twice: once by a global enable and once by a per-counter enable. When a counter carries past its top value, it latches a sticky overflow bit. That bit can raise a level interrupt.

Software reaches the bank through a plain word-addressed register port. Read data comes back one cycle after the read strobe. The control register holds the global enable. It also has two action bits that zero the counters and are never stored. Three masks (counter enable, interrupt enable and overflow status) each have a set address and a clear address. Counter values and type registers can be reached directly by index or indirectly through a select register. A software-increment register bumps chosen counters on demand. The cycle counter always sits at index 31 in every mask and index space.

Top module: `pmon_bank`

## Requirements
- R1: A counter advances by one on a clock edge only when control bit 0 (global enable) is 1, its bit in the counter-enable mask is 1 and its event is active on that edge. The cycle counter is index 31 and its event is active on every edge.
- R2: Type-register bits 9:0 hold the event number. Number 0x11 is active every cycle. A number n other than 0x00 and 0x11 with n < EVT_W follows evt_in[n]. Any other number is never active.
- R3: The control register (address 0x00) stores only bits 0, 3, 4 and 5. A read returns these bits ORed with 0x41 in bits 31:24, zero in bits 23:16 and NUM_CTR in bits 15:11.
- R4: A control write with bit 1 set zeroes every general counter, and with bit 2 set zeroes the cycle counter. Neither bit is stored. A zeroing write wins over an increment on the same edge.
- R5: The counter-enable mask sits at 0x01 (set) and 0x02 (clear), the interrupt-enable mask at 0x03/0x04 and the overflow-status mask at 0x05/0x06. A set write ORs in the written ones and a clear write removes them. Both addresses read the current mask.
- R6: With type bit 16 clear, a counter overflows when an increment finds its low 32 bits all ones. The low word wraps to zero and its overflow-status bit becomes 1. With bit 16 set, only an increment from all 64 bits ones overflows.
- R7: irq is 1 exactly while some overflow-status bit and its interrupt-enable bit are both 1. It changes on the same edge as the masks.
- R8: A write to 0x07 adds one to each enabled counter whose event number is 0x00 and whose bit is 1 in the written value. Reads of 0x07 return zero.
- R9: Writes to the cycle counter's type register store bits 31:27 and bit 16. Its event field always reads 0x11.
- R10: The type register of index i is at 0x20+i and its value at 0x40+i. The select register at 0x08 (bits 4:0) chooses the index for the type at 0x09 and the value at 0x0A. Value reads return the low 32 bits, and value writes load the zero-extended word.
- R11: Indices from NUM_CTR to 30 read as zero in every mask, type and value, and writes to them change nothing.
- R12: Read data appears on reg_rdata on the edge after reg_rd. Addresses outside the map read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | EVT_W | Per-cycle event pulses, indexed by event number |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume at least one general counter exists, since they watch the low word of counter 0. They also assume a write and a read never share a cycle at the control address. The sticky-status property takes a clear write to 0x06 as the only legal way for a status bit to fall. The bench keeps to these limits: it drives one register access at a time on falling edges, and it changes event pulses only between edges. Every counting window is therefore an exact number of enabled edges.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 5;
  localparam int CYC_IDX = 31;
  localparam int EV_W    = 10;

  localparam logic [EV_W-1:0] EV_SWINC = 10'h000;
  localparam logic [EV_W-1:0] EV_CYCLE = 10'h011;

  localparam int WIDE_BIT = 16;
  localparam int FILT_LO  = 27;

  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h0000_0039;
  localparam logic [7:0]       IMPL_CODE = 8'h41;
  localparam int CTRL_EN       = 0;
  localparam int CTRL_ZERO_EVT = 1;
  localparam int CTRL_ZERO_CYC = 2;

  localparam logic [7:0] A_CTRL     = 8'h00;
  localparam logic [7:0] A_CEN_SET  = 8'h01;
  localparam logic [7:0] A_CEN_CLR  = 8'h02;
  localparam logic [7:0] A_IEN_SET  = 8'h03;
  localparam logic [7:0] A_IEN_CLR  = 8'h04;
  localparam logic [7:0] A_OVS_SET  = 8'h05;
  localparam logic [7:0] A_OVS_CLR  = 8'h06;
  localparam logic [7:0] A_SWINC    = 8'h07;
  localparam logic [7:0] A_SEL      = 8'h08;
  localparam logic [7:0] A_ITYPE    = 8'h09;
  localparam logic [7:0] A_IVAL     = 8'h0A;
  localparam logic [7:0] A_TYPE_BLK = 8'h20;
  localparam logic [7:0] A_VAL_BLK  = 8'h40;
endpackage

// File: rtl/pmon_mask_reg.sv
module pmon_mask_reg #(
  parameter int         W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  // hardware set is applied after the clear, so a same-edge event stays sticky
  always_comb begin
    nxt = q;
    if (set_we) nxt = nxt | wdata;
    if (clr_we) nxt = nxt & ~wdata;
    nxt = (nxt | hw_set) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/pmon_ctr_slot.sv
module pmon_ctr_slot import pmon_pkg::*; #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int EVT_W    = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             sw_hit,
  input  logic             zero_req,
  input  logic             type_we,
  input  logic             val_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_val,
  output logic [REG_W-1:0] type_rd,
  output logic             ovf
);
  localparam int FILT_W = REG_W - FILT_LO;

  logic [CNT_W-1:0]  cnt_q;
  logic [FILT_W-1:0] filt_q;
  logic              wide_q;
  logic [EV_W-1:0]   ev_num;
  logic              hit;
  logic              at_top;
  logic              inc;

  if (IS_CYCLE) begin : g_cyc
    logic unused_inputs;
    assign unused_inputs = ^{evt_in, sw_hit};
    assign ev_num = EV_CYCLE;
    assign hit    = 1'b1;
  end else begin : g_evt
    logic [EV_W-1:0] ev_q;
    always_ff @(posedge clk) begin
      if (rst)          ev_q <= '0;
      else if (type_we) ev_q <= wdata[EV_W-1:0];
    end
    assign ev_num = ev_q;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < EVT_W; k++)
        if (ev_q == EV_W'(k)) hit = evt_in[k];
      if (ev_q == EV_SWINC) hit = sw_hit;
      if (ev_q == EV_CYCLE) hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= '0;
      wide_q <= 1'b0;
    end else if (type_we) begin
      filt_q <= wdata[REG_W-1:FILT_LO];
      wide_q <= wdata[WIDE_BIT];
    end
  end

  assign inc    = cnt_en & hit;
  assign at_top = wide_q ? (&cnt_q) : (&cnt_q[NARROW_W-1:0]);
  assign ovf    = inc & at_top & ~zero_req & ~val_we;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (zero_req) cnt_q <= '0;
    else if (val_we)   cnt_q <= CNT_W'(wdata);
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign rd_val  = cnt_q[REG_W-1:0];
  assign type_rd = {filt_q, {(FILT_LO-WIDE_BIT-1){1'b0}}, wide_q,
                    {(WIDE_BIT-EV_W){1'b0}}, ev_num};
endmodule

// File: rtl/pmon_bank.sv
module pmon_bank import pmon_pkg::*; #(
  parameter int NUM_CTR  = 4,
  parameter int EVT_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq
);
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [REG_W-1:0] IDX_KEEP =
    32'((64'd1 << NUM_CTR) - 64'd1) | (32'd1 << CYC_IDX);
  localparam logic [REG_W-1:0] CTRL_FIXED =
    {IMPL_CODE, 8'h00, 5'(NUM_CTR), 11'd0};
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(SLOTS - 1);

  // address decode
  logic hit_ctrl, hit_cset, hit_cclr, hit_iset, hit_iclr, hit_oset, hit_oclr;
  logic hit_swinc, hit_sel, hit_itype, hit_ival, is_dtype, is_dval;
  logic [IDX_W-1:0] didx;

  assign hit_ctrl  = reg_addr == ADDR_W'(A_CTRL);
  assign hit_cset  = reg_addr == ADDR_W'(A_CEN_SET);
  assign hit_cclr  = reg_addr == ADDR_W'(A_CEN_CLR);
  assign hit_iset  = reg_addr == ADDR_W'(A_IEN_SET);
  assign hit_iclr  = reg_addr == ADDR_W'(A_IEN_CLR);
  assign hit_oset  = reg_addr == ADDR_W'(A_OVS_SET);
  assign hit_oclr  = reg_addr == ADDR_W'(A_OVS_CLR);
  assign hit_swinc = reg_addr == ADDR_W'(A_SWINC);
  assign hit_sel   = reg_addr == ADDR_W'(A_SEL);
  assign hit_itype = reg_addr == ADDR_W'(A_ITYPE);
  assign hit_ival  = reg_addr == ADDR_W'(A_IVAL);
  assign is_dtype  = (reg_addr & BLK_MASK) == ADDR_W'(A_TYPE_BLK);
  assign is_dval   = (reg_addr & BLK_MASK) == ADDR_W'(A_VAL_BLK);
  assign didx      = reg_addr[IDX_W-1:0];

  // control and select
  logic [REG_W-1:0] ctrl_q;
  logic [IDX_W-1:0] sel_q;
  logic             zero_evt, zero_cyc;

  assign zero_evt = reg_wr & hit_ctrl & reg_wdata[CTRL_ZERO_EVT];
  assign zero_cyc = reg_wr & hit_ctrl & reg_wdata[CTRL_ZERO_CYC];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (reg_wr) begin
      if (hit_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
      if (hit_sel)  sel_q  <= reg_wdata[IDX_W-1:0];
    end
  end

  // masks
  logic [REG_W-1:0] cnten_q, inten_q, ovs_q;
  logic [REG_W-1:0] cnten_nxt_unused, inten_nxt, ovs_nxt;
  logic [REG_W-1:0] ovf_a;

  pmon_mask_reg #(.W(REG_W), .KEEP(IDX_KEEP)) u_cnten (
    .clk(clk), .rst(rst), .set_we(reg_wr & hit_cset), .clr_we(reg_wr & hit_cclr),
    .wdata(reg_wdata), .hw_set('0), .q(cnten_q), .nxt(cnten_nxt_unused));

  pmon_mask_reg #(.W(REG_W), .KEEP(IDX_KEEP)) u_inten (
    .clk(clk), .rst(rst), .set_we(reg_wr & hit_iset), .clr_we(reg_wr & hit_iclr),
    .wdata(reg_wdata), .hw_set('0), .q(inten_q), .nxt(inten_nxt));

  pmon_mask_reg #(.W(REG_W), .KEEP(IDX_KEEP)) u_ovs (
    .clk(clk), .rst(rst), .set_we(reg_wr & hit_oset), .clr_we(reg_wr & hit_oclr),
    .wdata(reg_wdata), .hw_set(ovf_a), .q(ovs_q), .nxt(ovs_nxt));

  // counter slots
  logic [REG_W-1:0] type_a [SLOTS];
  logic [REG_W-1:0] val_a  [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CTR || i == CYC_IDX) begin : g_live
      logic tw, vw;
      assign tw = reg_wr & ((is_dtype & (didx == IDX_W'(i))) |
                            (hit_itype & (sel_q == IDX_W'(i))));
      assign vw = reg_wr & ((is_dval & (didx == IDX_W'(i))) |
                            (hit_ival & (sel_q == IDX_W'(i))));
      pmon_ctr_slot #(
        .CNT_W(CNT_W), .NARROW_W(NARROW_W), .EVT_W(EVT_W),
        .IS_CYCLE(i == CYC_IDX)
      ) u_slot (
        .clk(clk), .rst(rst),
        .cnt_en(ctrl_q[CTRL_EN] & cnten_q[i]),
        .evt_in(evt_in),
        .sw_hit(reg_wr & hit_swinc & reg_wdata[i]),
        .zero_req((i == CYC_IDX) ? zero_cyc : zero_evt),
        .type_we(tw), .val_we(vw), .wdata(reg_wdata),
        .rd_val(val_a[i]), .type_rd(type_a[i]), .ovf(ovf_a[i]));
    end else begin : g_none
      assign val_a[i]  = '0;
      assign type_a[i] = '0;
      assign ovf_a[i]  = 1'b0;
    end
  end

  // read path
  logic [IDX_W-1:0] rd_idx;
  logic [REG_W-1:0] rd_mux;

  assign rd_idx = (is_dtype | is_dval) ? didx : sel_q;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)                   rd_mux = CTRL_FIXED | ctrl_q;
    else if (hit_cset | hit_cclr)   rd_mux = cnten_q;
    else if (hit_iset | hit_iclr)   rd_mux = inten_q;
    else if (hit_oset | hit_oclr)   rd_mux = ovs_q;
    else if (hit_sel)               rd_mux = REG_W'(sel_q);
    else if (hit_itype | is_dtype)  rd_mux = type_a[rd_idx];
    else if (hit_ival | is_dval)    rd_mux = val_a[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= |(ovs_nxt & inten_nxt);
    end
  end
endmodule

// File: rtl/pmon_bank_chk.sv
module pmon_bank_chk import pmon_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq,
  input logic              glob_en,
  input logic [REG_W-1:0]  ovs,
  input logic [REG_W-1:0]  inten,
  input logic [REG_W-1:0]  cnt0
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (|(ovs & inten))); // R7

  AST_OVS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|($past(ovs) & ~ovs)) |-> $past(reg_wr && reg_addr == ADDR_W'(A_OVS_CLR))); // R6

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ($past(!glob_en) && !$past(reg_wr)) |-> $stable(cnt0)); // R1

  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && reg_addr == ADDR_W'(A_CTRL)) |->
      (reg_rdata[31:24] == IMPL_CODE && reg_rdata[2:1] == 2'b00)); // R3

  AST_SWINC_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd && reg_addr == ADDR_W'(A_SWINC)) |-> reg_rdata == '0); // R8

  AST_ZERO_ACTION: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[CTRL_ZERO_EVT])
      |-> cnt0 == '0); // R4
endmodule

bind pmon_bank pmon_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq(irq), .glob_en(ctrl_q[0]), .ovs(ovs_q), .inten(inten_q),
  .cnt0(val_a[0]));

// File: tb/sim_pmon_bank.sv
module sim_pmon_bank;
  localparam int NUM_CTR = 4;
  localparam int EVT_W   = 32;

  localparam logic [7:0] CTRL = 8'h00, CSET = 8'h01, CCLR = 8'h02;
  localparam logic [7:0] ISET = 8'h03, ICLR = 8'h04, OSET = 8'h05, OCLR = 8'h06;
  localparam logic [7:0] SWI  = 8'h07, SEL  = 8'h08, ITYP = 8'h09, IVAL = 8'h0A;
  localparam logic [7:0] TYP0 = 8'h20, VAL0 = 8'h40;
  localparam logic [31:0] CTRL_ID = 32'h4100_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [EVT_W-1:0] evt_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pmon_bank #(.NUM_CTR(NUM_CTR), .EVT_W(EVT_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(CTRL, d); chk("R3 reset control", d, CTRL_ID);
    rd(CSET, d); chk("R5 reset enable mask", d, 32'h0);
    chk("R7 reset irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(CTRL, 32'hFFFF_FFFE);
    rd(CTRL, d); chk("R3 stored bits only", d, CTRL_ID | 32'h38);
    wr(CTRL, 32'h0);
    rd(CTRL, d); chk("R3 cleared control", d, CTRL_ID);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wr(CSET, 32'hFFFF_FFFF);
    rd(CSET, d); chk("R11 enable mask limited", d, 32'h8000_000F);
    wr(CCLR, 32'h0000_0005);
    rd(CCLR, d); chk("R5 enable clear", d, 32'h8000_000A);
    wr(ISET, 32'h0000_0042);
    rd(ICLR, d); chk("R5 interrupt set", d, 32'h0000_0002);
    wr(ICLR, 32'hFFFF_FFFF);
    wr(CCLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(TYP0 + 8'd0, 32'd3);
    wr(TYP0 + 8'd1, 32'd5);
    wr(CSET, 32'h3);
    evt_in = 32'h8; idle(5); evt_in = '0;
    rd(VAL0, d); chk("R1 no count while globally off", d, 32'd0);
    wr(CTRL, 32'h1);
    evt_in = (32'h1 << 3) | (32'h1 << 5); idle(2);
    evt_in = 32'h1 << 3; idle(2);
    evt_in = '0;
    wr(CTRL, 32'h0);
    rd(VAL0 + 8'd0, d); chk("R2 counter 0 follows event 3", d, 32'd4);
    rd(VAL0 + 8'd1, d); chk("R2 counter 1 follows event 5", d, 32'd2);
  endtask

  task automatic t_cycle;
    logic [31:0] d;
    wr(TYP0 + 8'd3, 32'h11);
    wr(TYP0 + 8'd2, 32'd40);
    wr(CSET, 32'h8000_000C);
    wr(CTRL, 32'h1);
    evt_in = '1; idle(9); evt_in = '0;
    wr(CTRL, 32'h0);
    rd(VAL0 + 8'd31, d); chk("R1 cycle counter", d, 32'd10);
    rd(VAL0 + 8'd3, d);  chk("R2 event 0x11 every cycle", d, 32'd10);
    rd(VAL0 + 8'd2, d);  chk("R2 event beyond range", d, 32'd0);
    wr(TYP0 + 8'd31, 32'hFFFF_FFFF);
    rd(TYP0 + 8'd31, d); chk("R9 cycle type full write", d, 32'hF801_0011);
    wr(TYP0 + 8'd31, 32'h0);
    rd(TYP0 + 8'd31, d); chk("R9 cycle type cleared", d, 32'h0000_0011);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(CTRL, 32'h2);
    rd(VAL0 + 8'd3, d);  chk("R4 event counters zeroed", d, 32'd0);
    rd(VAL0 + 8'd31, d); chk("R4 cycle kept", d, 32'd10);
    rd(CTRL, d);         chk("R4 action bit not stored", d, CTRL_ID);
    wr(CTRL, 32'h4);
    rd(VAL0 + 8'd31, d); chk("R4 cycle zeroed", d, 32'd0);
  endtask

  task automatic t_ovf;
    logic [31:0] d;
    wr(CCLR, 32'hFFFF_FFFF);
    wr(CSET, 32'h1);
    wr(TYP0, 32'd3);
    wr(VAL0, 32'hFFFF_FFFE);
    wr(ISET, 32'h1);
    wr(CTRL, 32'h1);
    evt_in = 32'h1 << 3; idle(2); evt_in = '0;
    wr(CTRL, 32'h0);
    rd(VAL0, d); chk("R6 narrow wrap", d, 32'd0);
    rd(OSET, d); chk("R6 overflow status", d, 32'h1);
    chk("R7 irq raised", {31'd0, irq}, 32'h1);
    wr(OCLR, 32'h1);
    chk("R7 irq dropped on clear", {31'd0, irq}, 32'h0);
    wr(CSET, 32'h2);
    wr(VAL0 + 8'd1, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    evt_in = 32'h1 << 5; idle(1); evt_in = '0;
    wr(CTRL, 32'h0);
    rd(OCLR, d); chk("R6 status without interrupt", d, 32'h2);
    chk("R7 irq masked", {31'd0, irq}, 32'h0);
    wr(ISET, 32'h2);
    chk("R7 irq on enable", {31'd0, irq}, 32'h1);
    wr(OCLR, 32'h2);
    wr(ICLR, 32'h3);
  endtask

  task automatic t_wide;
    logic [31:0] d;
    wr(CSET, 32'h4);
    wr(TYP0 + 8'd2, 32'h0001_0007);
    wr(VAL0 + 8'd2, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    evt_in = 32'h1 << 7; idle(1); evt_in = '0;
    wr(CTRL, 32'h0);
    rd(VAL0 + 8'd2, d); chk("R6 wide low word wraps", d, 32'd0);
    rd(OSET, d);        chk("R6 wide no overflow", d, 32'h0);
    rd(TYP0 + 8'd2, d); chk("R6 wide flag readback", d, 32'h0001_0007);
  endtask

  task automatic t_swinc;
    logic [31:0] d;
    wr(TYP0, 32'h0);
    wr(TYP0 + 8'd1, 32'h0);
    wr(VAL0, 32'h0);
    wr(VAL0 + 8'd1, 32'h0);
    wr(CTRL, 32'h1);
    wr(SWI, 32'h5);
    wr(SWI, 32'h3);
    wr(CTRL, 32'h0);
    rd(VAL0, d);        chk("R8 counter 0 stepped twice", d, 32'd2);
    rd(VAL0 + 8'd1, d); chk("R8 counter 1 stepped once", d, 32'd1);
    rd(VAL0 + 8'd2, d); chk("R8 other event type untouched", d, 32'd0);
    rd(SWI, d);         chk("R8 reads zero", d, 32'd0);
  endtask

  task automatic t_indirect;
    logic [31:0] d;
    wr(SEL, 32'd1);
    wr(IVAL, 32'h1234);
    wr(ITYP, 32'h0900_000A);
    rd(VAL0 + 8'd1, d); chk("R10 indirect value write", d, 32'h1234);
    rd(TYP0 + 8'd1, d); chk("R10 indirect type write", d, 32'h0800_000A);
    rd(SEL, d);         chk("R10 select readback", d, 32'd1);
    rd(IVAL, d);        chk("R10 indirect value read", d, 32'h1234);
    wr(SEL, 32'd31);
    wr(IVAL, 32'd7);
    rd(VAL0 + 8'd31, d); chk("R10 indirect cycle value", d, 32'd7);
  endtask

  task automatic t_absent;
    logic [31:0] d;
    wr(VAL0 + 8'd5, 32'hABCD);
    rd(VAL0 + 8'd5, d); chk("R11 absent value", d, 32'd0);
    wr(TYP0 + 8'd5, 32'h3);
    rd(TYP0 + 8'd5, d); chk("R11 absent type", d, 32'd0);
    wr(SEL, 32'd6);
    rd(ITYP, d);        chk("R11 absent indirect", d, 32'd0);
    rd(8'h10, d);       chk("R12 unmapped address", d, 32'd0);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset;
    t_ctrl;
    t_masks;
    t_count;
    t_cycle;
    t_zero;
    t_ovf;
    t_wide;
    t_swinc;
    t_indirect;
    t_absent;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule